// File: doc/BRIEF.md
# Banked Register File Controller

This block sits between an 8-bit microcontroller core and its data memory. The data memory is split into two banks of 128 locations each. In every bank the low offsets hold special-function registers and the offsets above them hold general-purpose bytes. The core presents a 7-bit offset taken from the instruction, the current bank-select bit, the value of its pointer register, read and write strobes, and write data. The block turns these into a full 8-bit address. It then steers the access either to an external special-function register bus or to its own byte storage, and returns read data to the core.

Only the special-function region is truly banked. The general-purpose bytes are one physical store that appears at the same offsets in both banks. Offset 00h is reserved for indirection: an access there uses the pointer register as the full address instead. This means any location in either bank can be reached without touching the bank bit.

Writes land on the rising clock edge. Reads are combinational, so a value written in one cycle can be read in the next.

Top module: `bank_regfile`

## Requirements
- R1: For a direct access (offset not 00h) the full address is `{bank_sel, dir_ofs}`. Bank 0 is selected when bank_sel is 0 and bank 1 when it is 1.
- R2: Offsets 01h to 0Bh are special-function locations. An access to one of them drives `sfr_addr` with the full 8-bit address and `sfr_wdata` with the write data. It raises `sfr_rd` while `rd_en` is high and `sfr_wr` while `wr_en` is high. The bank bit (address bit 7) separates 03h from 83h.
- R3: General-purpose offsets are shared by both banks. A byte written at full address `x` (offset 0Ch to 4Fh) reads back identically at `x ^ 80h`.
- R4: General-purpose offsets 0Ch to 4Fh are 68 independent 8-bit cells. A write takes effect at the rising clock edge. A read returns the stored byte combinationally in the same cycle.
- R5: When `dir_ofs` is 00h, the full address is taken from `fsr_val`, and bit 7 of `fsr_val` acts as the bank bit. The access then behaves exactly as a direct access to that address would.
- R6: An indirect access whose target offset (`fsr_val[6:0]`) is 00h reads as 00h. A write to it changes no storage and raises no bus strobe.
- R7: Offsets 50h to 7Fh in either bank are unimplemented. They read as 00h, writes to them are discarded, and they raise no bus strobe.
- R8: During a special-function read, `rd_data` equals `sfr_rdata` unchanged. Neither bus strobe is raised for any access outside 01h to 0Bh.
- R9: While `rd_en` is low, `rd_data` is 00h.
- R10: Asserting `rst` leaves the general-purpose contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst | input | 1 | Synchronous active-high reset; does not clear storage |
| bank_sel | input | 1 | Bank-select bit from the status register |
| dir_ofs | input | 7 | Offset field from the instruction; 00h means indirect |
| fsr_val | input | 8 | Pointer register value used as the full address for indirect access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Data to write |
| rd_data | output | 8 | Read data returned to the core |
| sfr_addr | output | 8 | Full address on the special-function bus |
| sfr_rd | output | 1 | Special-function read strobe |
| sfr_wr | output | 1 | Special-function write strobe |
| sfr_wdata | output | 8 | Write data on the special-function bus |
| sfr_rdata | input | 8 | Read data from the special-function bus |

## Verification
Every full address from 00h to FFh is written through the direct path. Bank 0 goes first and bank 1 second, so any general-purpose cell that fails to alias shows the bank-0 value instead of the bank-1 value. Every address is then read back twice: once directly and once through the pointer with `dir_ofs` at 00h. This sweep separates the special-function, general-purpose, unimplemented and null-target regions, and catches a wrong bank bit on the bus. A bus model returns `address ^ 5Ah`, so pass-through and address errors both show up in the read data. Targeted writes cover the indirect path, the null target, the unimplemented area and reset. Each is followed by a full readback of general-purpose storage to show that nothing else changed.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic [1:0] {
    RGN_NULL = 2'd0,
    RGN_SFR  = 2'd1,
    RGN_GPR  = 2'd2,
    RGN_VOID = 2'd3
  } rgn_e;
endpackage

// File: rtl/brf_addr_resolve.sv
module brf_addr_resolve
  import brf_pkg::*;
#(
  parameter int OFS_W    = 7,
  parameter int SFR_CNT  = 12,
  parameter int GPR_LAST = 79,
  localparam int ADDR_W  = OFS_W + 1
) (
  input  logic              bank_sel,
  input  logic [OFS_W-1:0]  dir_ofs,
  input  logic [ADDR_W-1:0] ptr_val,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              is_indirect,
  output rgn_e              rgn
);
  localparam logic [OFS_W-1:0] SFR_END  = OFS_W'(SFR_CNT);
  localparam logic [OFS_W-1:0] GPR_TOP  = OFS_W'(GPR_LAST);

  logic [OFS_W-1:0] eff_ofs;

  always_comb begin
    is_indirect = (dir_ofs == '0);
    eff_addr    = is_indirect ? ptr_val : {bank_sel, dir_ofs};
    eff_ofs     = eff_addr[OFS_W-1:0];
    if (eff_ofs == '0)
      rgn = RGN_NULL;
    else if (eff_ofs < SFR_END)
      rgn = RGN_SFR;
    else if (eff_ofs <= GPR_TOP)
      rgn = RGN_GPR;
    else
      rgn = RGN_VOID;
  end
endmodule

// File: rtl/brf_gpr_ram.sv
module brf_gpr_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 68,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  // No reset on the array: contents are undefined at power-up (R10)
  always_ff @(posedge clk) begin
    if (we)
      cells[idx] <= wdata;
  end

  always_comb begin
    if (32'(idx) < DEPTH)
      rdata = cells[idx];
    else
      rdata = '0;
  end

  // R4: a write is visible in the addressed cell after the edge
  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (cells[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/brf_sfr_port.sv
module brf_sfr_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    bus_addr  = addr;
    bus_wdata = wdata;
    bus_rd    = sel & rd_en;
    bus_wr    = sel & wr_en;
    rdata     = bus_rdata;
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import brf_pkg::*;
#(
  parameter int OFS_W    = 7,
  parameter int DATA_W   = 8,
  parameter int SFR_CNT  = 12,
  parameter int GPR_LAST = 79,
  localparam int ADDR_W    = OFS_W + 1,
  localparam int GPR_DEPTH = GPR_LAST - SFR_CNT + 1,
  localparam int IDX_W     = $clog2(GPR_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_sel,
  input  logic [OFS_W-1:0]  dir_ofs,
  input  logic [ADDR_W-1:0] fsr_val,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic              sfr_rd,
  output logic              sfr_wr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  localparam logic [OFS_W-1:0] GPR_BASE = OFS_W'(SFR_CNT);

  logic [ADDR_W-1:0] eff_addr;
  logic              is_indirect;
  rgn_e              rgn;
  logic [OFS_W-1:0]  gpr_rel;
  logic [IDX_W-1:0]  gpr_idx;
  logic              gpr_we;
  logic [DATA_W-1:0] gpr_rdata;
  logic [DATA_W-1:0] sfr_rd_val;

  brf_addr_resolve #(
    .OFS_W(OFS_W), .SFR_CNT(SFR_CNT), .GPR_LAST(GPR_LAST)
  ) u_resolve (
    .bank_sel(bank_sel), .dir_ofs(dir_ofs), .ptr_val(fsr_val),
    .eff_addr(eff_addr), .is_indirect(is_indirect), .rgn(rgn)
  );

  // Bank bit is dropped here, so both banks share one cell (R3)
  always_comb begin
    gpr_rel = eff_addr[OFS_W-1:0] - GPR_BASE;
    gpr_idx = IDX_W'(gpr_rel);
    gpr_we  = wr_en && (rgn == RGN_GPR);
  end

  brf_gpr_ram #(.DATA_W(DATA_W), .DEPTH(GPR_DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(gpr_we), .idx(gpr_idx),
    .wdata(wr_data), .rdata(gpr_rdata)
  );

  brf_sfr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sfr (
    .sel(rgn == RGN_SFR), .rd_en(rd_en), .wr_en(wr_en),
    .addr(eff_addr), .wdata(wr_data), .bus_rdata(sfr_rdata),
    .bus_addr(sfr_addr), .bus_rd(sfr_rd), .bus_wr(sfr_wr),
    .bus_wdata(sfr_wdata), .rdata(sfr_rd_val)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (rgn)
        RGN_SFR: rd_data = sfr_rd_val;
        RGN_GPR: rd_data = gpr_rdata;
        default: rd_data = '0;
      endcase
    end
  end

  // R1: direct special-function reads carry {bank, offset}
  a_r1_direct_addr: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd && dir_ofs != '0) |-> (sfr_addr == {bank_sel, dir_ofs}));

  // R5: indirect bus accesses carry the pointer value
  a_r5_indirect_addr: assert property (@(posedge clk) disable iff (rst)
    ((sfr_rd || sfr_wr) && dir_ofs == '0) |-> (sfr_addr == fsr_val));

  // R6: null target raises no strobe and reads zero
  a_r6_null_target: assert property (@(posedge clk) disable iff (rst)
    (is_indirect && fsr_val[OFS_W-1:0] == '0) |->
      (!sfr_rd && !sfr_wr && rd_data == '0));

  // R8: strobes only for special-function offsets
  a_r8_strobe_region: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd || sfr_wr) |->
      (sfr_addr[OFS_W-1:0] != '0 && sfr_addr[OFS_W-1:0] < GPR_BASE));

  // R7: unimplemented offsets read zero
  a_r7_void_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rgn == RGN_VOID) |-> (rd_data == '0));

  // R9: idle read port returns zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == '0));
endmodule

// File: tb/bank_regfile_bench.sv
`timescale 1ns/1ps
module bank_regfile_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bank_sel = 1'b0;
  logic [6:0] dir_ofs = 7'd0;
  logic [7:0] fsr_val = 8'd0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic [7:0] sfr_addr;
  logic       sfr_rd;
  logic       sfr_wr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [7:0] model [128];

  always #2 clk = ~clk;

  assign sfr_rdata = sfr_addr ^ 8'h5A;

  bank_regfile u_bank_regfile (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .dir_ofs(dir_ofs),
    .fsr_val(fsr_val), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic bit is_sfr(input logic [7:0] a);
    return (a[6:0] != 0) && (a[6:0] < 7'd12);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [6:0] o;
    o = a[6:0];
    if (o == 0) return 8'h00;
    if (o < 7'd12) return a ^ 8'h5A;
    if (o <= 7'h4F) return model[o];
    return 8'h00;
  endfunction

  task automatic access(input bit ind, input logic [7:0] a, input bit rd,
                        input bit wr, input logic [7:0] wd);
    @(negedge clk);
    if (ind) begin
      dir_ofs = 7'd0; fsr_val = a; bank_sel = ~a[7];
    end else begin
      dir_ofs = a[6:0]; bank_sel = a[7]; fsr_val = 8'h00;
    end
    rd_en = rd; wr_en = wr; wr_data = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic gpr_readback(input string req);
    for (int o = 12; o <= 79; o++) begin
      access(1'b0, 8'(o), 1'b1, 1'b0, 8'h00);
      chk(req, rd_data, model[o]);
    end
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: idle read port
    #1 chk("R9 idle after reset", rd_data, 8'h00);

    // Direct write sweep, bank 0 then bank 1
    for (int a = 0; a < 256; a++) begin
      if (a[6:0] == 0) continue;
      access(1'b0, 8'(a), 1'b0, 1'b1, 8'(a * 7 + 3));
      if (is_sfr(8'(a))) begin
        chk("R2 sfr_wr", {7'd0, sfr_wr}, 8'h01);
        chk("R1 direct sfr_addr", sfr_addr, 8'(a));
        chk("R2 sfr_wdata", sfr_wdata, 8'(a * 7 + 3));
      end else begin
        chk("R8 no strobe", {6'd0, sfr_rd, sfr_wr}, 8'h00);
        if (a[6:0] <= 7'h4F) model[a[6:0]] = 8'(a * 7 + 3);
      end
    end
    idle();

    // Direct read sweep (R1 R2 R3 R4 R7 R8)
    for (int a = 0; a < 256; a++) begin
      if (a[6:0] == 0) continue;
      access(1'b0, 8'(a), 1'b1, 1'b0, 8'h00);
      chk("R3 R7 R8 direct read", rd_data, exp_read(8'(a)));
      chk("R2 sfr_rd", {7'd0, sfr_rd}, {7'd0, is_sfr(8'(a))});
    end
    idle();

    // Indirect read sweep (R5 R6)
    for (int a = 0; a < 256; a++) begin
      access(1'b1, 8'(a), 1'b1, 1'b0, 8'h00);
      chk("R5 R6 indirect read", rd_data, exp_read(8'(a)));
      chk("R5 indirect sfr_rd", {7'd0, sfr_rd}, {7'd0, is_sfr(8'(a))});
      if (is_sfr(8'(a))) chk("R5 indirect sfr_addr", sfr_addr, 8'(a));
    end
    idle();

    // R5: indirect write into bank-1 GPR alias, read back in bank 0
    access(1'b1, 8'hA0, 1'b0, 1'b1, 8'hA5);
    model[7'h20] = 8'hA5;
    access(1'b0, 8'h20, 1'b1, 1'b0, 8'h00);
    chk("R5 R3 indirect write", rd_data, 8'hA5);
    access(1'b1, 8'h83, 1'b0, 1'b1, 8'h3C);
    chk("R5 indirect sfr_wr", {7'd0, sfr_wr}, 8'h01);
    chk("R5 indirect sfr_addr", sfr_addr, 8'h83);
    idle();

    // R6: writes to the null target
    access(1'b1, 8'h80, 1'b0, 1'b1, 8'h77);
    chk("R6 null write strobe", {6'd0, sfr_rd, sfr_wr}, 8'h00);
    access(1'b1, 8'h00, 1'b1, 1'b1, 8'h66);
    chk("R6 null read", rd_data, 8'h00);
    chk("R6 null strobe", {6'd0, sfr_rd, sfr_wr}, 8'h00);
    idle();
    gpr_readback("R6 storage untouched");

    // R7: writes to unimplemented offsets
    access(1'b0, 8'hD5, 1'b0, 1'b1, 8'hEE);
    chk("R7 void strobe", {6'd0, sfr_rd, sfr_wr}, 8'h00);
    access(1'b0, 8'h50, 1'b0, 1'b1, 8'hEE);
    access(1'b0, 8'h7F, 1'b1, 1'b0, 8'h00);
    chk("R7 void read", rd_data, 8'h00);
    access(1'b0, 8'h50, 1'b1, 1'b0, 8'h00);
    chk("R7 void read 50h", rd_data, 8'h00);
    idle();
    gpr_readback("R7 storage untouched");

    // R4: boundary cells and back-to-back writes
    access(1'b0, 8'h0C, 1'b0, 1'b1, 8'h11); model[7'h0C] = 8'h11;
    access(1'b0, 8'hCF, 1'b0, 1'b1, 8'h22); model[7'h4F] = 8'h22;
    access(1'b0, 8'h0C, 1'b1, 1'b0, 8'h00);
    chk("R4 first cell", rd_data, 8'h11);
    access(1'b0, 8'h4F, 1'b1, 1'b0, 8'h00);
    chk("R4 last cell", rd_data, 8'h22);
    access(1'b0, 8'h8C, 1'b1, 1'b0, 8'h00);
    chk("R3 alias 8Ch", rd_data, 8'h11);
    idle();

    // R10: reset keeps storage
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    gpr_readback("R10 after reset");

    // R9: read strobe low
    access(1'b0, 8'h0C, 1'b0, 1'b0, 8'h00);
    chk("R9 idle gpr", rd_data, 8'h00);
    access(1'b0, 8'h03, 1'b0, 1'b0, 8'h00);
    chk("R9 idle sfr", rd_data, 8'h00);
    chk("R8 no strobe idle", {6'd0, sfr_rd, sfr_wr}, 8'h00);
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule